// File: doc/BRIEF.md
# Contactless Transceiver Modem Sequencer

This block is the control sequencer for one half-duplex exchange of a contactless reader. A host command starts it. It either sends a frame, listens for a card frame, or sends a frame and then listens for the reply. On the send side it steps the transmit coder through start-of-frame, payload and end-of-frame phases, each closed by a done handshake from the coder. On the listen side it first waits a programmable number of bit-grid periods, then arms the receiver. It waits for the card's start-of-frame and receives until the frame ends.

The sequencer raises one-cycle interrupt pulses when transmission is complete, when reception is complete and whenever it returns to idle. A frame that the decoder flags as an electromagnetic disturbance is dropped silently and the sequencer waits for a new start-of-frame. The 3-bit state code is exported so that a status register can show it. The coders, decoders, buffer and analog front end are outside this block; their handshakes arrive as single-cycle input pulses.

Top module: `xcvr_modem_seq`

## Requirements
- R1: The state code on `modemState` is Idle 000, TxSOF 001, TxData 010, TxEOF 011, RxPrepare 100, RxAwaiting 101, Receiving 110. The code 111 never appears. Reset leaves Idle with every pulse output low.
- R2: In Idle, with `cmdValid` high, `cmdCode` selects the next state. Send (01) and Exchange (11) go to TxSOF. Listen (10) goes to RxPrepare. Code 00 has no effect. A command given in any state other than Idle is ignored and the state is kept.
- R3: TxSOF moves to TxData on `txSofDone`. TxData moves to TxEOF on `txDataDone`. `txIrq` pulses in the first TxEOF cycle.
- R4: In TxEOF, `txEofDone` moves an Exchange on to RxPrepare and moves a Send back to Idle.
- R5: On entry to RxPrepare the wait count is loaded from the 8-bit `rxWait`. Each `gridTick` lowers the count by one. The tick that finds the count at zero moves the state to RxAwaiting, so arming happens on tick number `rxWait`+1, and a value of 0 arms on the first tick. `rxStart` pulses in the first RxAwaiting cycle. Cycles without a tick do not change the count.
- R6: RxAwaiting moves to Receiving on `cardSofDet`.
- R7: In Receiving, `emdFlag` returns the state to RxAwaiting with no `rxIrq` and no `idleIrq`. It takes priority over the other frame-end inputs in the same cycle.
- R8: In Receiving, `rxEofOk` returns to Idle. `rxIrq` pulses in the first Idle cycle.
- R9: In Receiving, `rxNoEof` (frame ended with no end-of-frame) returns to Idle with an `rxIrq` pulse. In the same cycle `framingErr` pulses, unless `ignoreMissingEof` was high when `rxNoEof` was seen.
- R10: `idleIrq` pulses in the first cycle of every return to Idle, but not after reset. `stopReq` forces Idle from any non-Idle state, with priority over every other input. In Idle, `stopReq` has no effect and gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Host command strobe |
| cmdCode | input | 2 | 01 Send, 10 Listen, 11 Exchange |
| stopReq | input | 1 | Host stop, forces Idle |
| rxWait | input | 8 | Bit-grid periods to wait before arming the receiver |
| ignoreMissingEof | input | 1 | Suppresses the framing error for a missing end-of-frame |
| txSofDone | input | 1 | Coder finished start-of-frame |
| txDataDone | input | 1 | Coder finished payload |
| txEofDone | input | 1 | Coder finished end-of-frame |
| gridTick | input | 1 | Bit-grid period tick |
| cardSofDet | input | 1 | Decoder saw card start-of-frame |
| emdFlag | input | 1 | Decoder flags the frame as disturbance |
| rxEofOk | input | 1 | Frame ended with a valid end-of-frame |
| rxNoEof | input | 1 | Frame ended without an end-of-frame |
| modemState | output | 3 | Current state code |
| txIrq | output | 1 | Transmit-complete pulse |
| rxIrq | output | 1 | Receive-complete pulse |
| idleIrq | output | 1 | Return-to-idle pulse |
| rxStart | output | 1 | Receiver-arm pulse |
| framingErr | output | 1 | Missing end-of-frame pulse |

## Verification
The stimulus covers several exchange shapes:
- A plain Send, which shows that a transmit returns straight to Idle.
- An Exchange with a nonzero wait, with idle cycles between ticks. This separates counting ticks from counting cycles and checks the count+1 arming rule.
- Listens with a zero wait, which check first-tick arming.
- A disturbance frame followed by a good frame, which shows that disturbance goes back to awaiting and does not report anything.
- Missing end-of-frame with the ignore control low and high, which separates the error pulse from the receive pulse.
- Stops issued mid-transmit, during a long wait, and while idle, which check both the stop priority and that a stop in Idle has no effect.
- Commands issued while busy, which must be ignored.

// File: rtl/xcvr_modem_seq_pkg.sv
package xcvr_modem_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'b000,
    ST_TX_SOF   = 3'b001,
    ST_TX_DATA  = 3'b010,
    ST_TX_EOF   = 3'b011,
    ST_RX_PREP  = 3'b100,
    ST_RX_AWAIT = 3'b101,
    ST_RX_BUSY  = 3'b110
  } modemState_e;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'b00,
    CMD_SEND     = 2'b01,
    CMD_LISTEN   = 2'b10,
    CMD_EXCHANGE = 2'b11
  } hostCmd_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadWait;
    logic countTick;
    logic txDone;
    logic rxDone;
    logic armRx;
    logic backToIdle;
    logic frameErr;
  } seqStrobe_t;

endpackage

// File: rtl/xcvr_modem_seq_ctrl.sv
module xcvr_modem_seq_ctrl
  import xcvr_modem_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdCode,
  input  logic        stopReq,
  input  logic        ignoreMissingEof,
  input  logic        txSofDone,
  input  logic        txDataDone,
  input  logic        txEofDone,
  input  logic        gridTick,
  input  logic        cardSofDet,
  input  logic        emdFlag,
  input  logic        rxEofOk,
  input  logic        rxNoEof,
  input  logic        waitZero,
  output modemState_e stateQ,
  output seqStrobe_t  strobe
);

  modemState_e stateD;
  logic        exchangeQ, exchangeD;

  always_comb begin
    stateD    = stateQ;
    exchangeD = exchangeQ;
    strobe    = '0;
    if (stopReq && (stateQ != ST_IDLE)) begin
      // host stop wins over every handshake
      stateD            = ST_IDLE;
      strobe.backToIdle = 1'b1;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (cmdValid) begin
            case (hostCmd_e'(cmdCode))
              CMD_SEND: begin
                stateD    = ST_TX_SOF;
                exchangeD = 1'b0;
              end
              CMD_EXCHANGE: begin
                stateD    = ST_TX_SOF;
                exchangeD = 1'b1;
              end
              CMD_LISTEN: begin
                stateD          = ST_RX_PREP;
                strobe.loadWait = 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_TX_SOF: begin
          if (txSofDone) stateD = ST_TX_DATA;
        end
        ST_TX_DATA: begin
          if (txDataDone) begin
            stateD        = ST_TX_EOF;
            strobe.txDone = 1'b1;
          end
        end
        ST_TX_EOF: begin
          if (txEofDone) begin
            if (exchangeQ) begin
              stateD          = ST_RX_PREP;
              strobe.loadWait = 1'b1;
            end else begin
              stateD            = ST_IDLE;
              strobe.backToIdle = 1'b1;
            end
          end
        end
        ST_RX_PREP: begin
          if (gridTick) begin
            if (waitZero) begin
              stateD       = ST_RX_AWAIT;
              strobe.armRx = 1'b1;
            end else begin
              strobe.countTick = 1'b1;
            end
          end
        end
        ST_RX_AWAIT: begin
          if (cardSofDet) stateD = ST_RX_BUSY;
        end
        ST_RX_BUSY: begin
          if (emdFlag) begin
            stateD = ST_RX_AWAIT;
          end else if (rxEofOk || rxNoEof) begin
            stateD            = ST_IDLE;
            strobe.rxDone     = 1'b1;
            strobe.backToIdle = 1'b1;
            strobe.frameErr   = !rxEofOk && !ignoreMissingEof;
          end
        end
        default: begin
          stateD            = ST_IDLE;
          strobe.backToIdle = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      exchangeQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      exchangeQ <= exchangeD;
    end
  end

endmodule

// File: rtl/xcvr_modem_seq_dp.sv
module xcvr_modem_seq_dp
  import xcvr_modem_seq_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [WAIT_W-1:0] rxWait,
  output logic              waitZero,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              idleIrq,
  output logic              rxStart,
  output logic              framingErr
);

  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 waitCnt <= '0;
    else if (strobe.loadWait)  waitCnt <= rxWait;
    else if (strobe.countTick) waitCnt <= waitCnt - 1'b1;
  end

  assign waitZero = (waitCnt == '0);

  // pulses line up with the first cycle of the new state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIrq      <= 1'b0;
      rxIrq      <= 1'b0;
      idleIrq    <= 1'b0;
      rxStart    <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      txIrq      <= strobe.txDone;
      rxIrq      <= strobe.rxDone;
      idleIrq    <= strobe.backToIdle;
      rxStart    <= strobe.armRx;
      framingErr <= strobe.frameErr;
    end
  end

endmodule

// File: rtl/xcvr_modem_seq.sv
module xcvr_modem_seq
  import xcvr_modem_seq_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdCode,
  input  logic              stopReq,
  input  logic [WAIT_W-1:0] rxWait,
  input  logic              ignoreMissingEof,
  input  logic              txSofDone,
  input  logic              txDataDone,
  input  logic              txEofDone,
  input  logic              gridTick,
  input  logic              cardSofDet,
  input  logic              emdFlag,
  input  logic              rxEofOk,
  input  logic              rxNoEof,
  output logic [2:0]        modemState,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              idleIrq,
  output logic              rxStart,
  output logic              framingErr
);

  modemState_e stateQ;
  seqStrobe_t  strobe;
  logic        waitZero;

  xcvr_modem_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .stopReq(stopReq), .ignoreMissingEof(ignoreMissingEof),
    .txSofDone(txSofDone), .txDataDone(txDataDone), .txEofDone(txEofDone),
    .gridTick(gridTick), .cardSofDet(cardSofDet), .emdFlag(emdFlag),
    .rxEofOk(rxEofOk), .rxNoEof(rxNoEof), .waitZero(waitZero),
    .stateQ(stateQ), .strobe(strobe)
  );

  xcvr_modem_seq_dp #(.WAIT_W(WAIT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxWait(rxWait),
    .waitZero(waitZero), .txIrq(txIrq), .rxIrq(rxIrq), .idleIrq(idleIrq),
    .rxStart(rxStart), .framingErr(framingErr)
  );

  assign modemState = stateQ;

endmodule

// File: rtl/xcvr_modem_seq_chk.sv
module xcvr_modem_seq_chk #(
  parameter int WAIT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [1:0]        cmdCode,
  input logic              stopReq,
  input logic [WAIT_W-1:0] rxWait,
  input logic              ignoreMissingEof,
  input logic              emdFlag,
  input logic [2:0]        modemState,
  input logic              txIrq,
  input logic              rxIrq,
  input logic              idleIrq,
  input logic              rxStart,
  input logic              framingErr
);

  p_legal_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    modemState != 3'b111);

  p_tx_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modemState == 3'b000 && cmdValid && cmdCode[0] && !stopReq) |=> modemState == 3'b001);

  p_rx_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modemState == 3'b000 && cmdValid && cmdCode == 2'b10 && !stopReq) |=> modemState == 3'b100);

  p_tx_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> (modemState == 3'b011 && $past(modemState) == 3'b010));

  p_arm_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxStart |-> (modemState == 3'b101 && $past(modemState) == 3'b100));

  p_emd_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modemState == 3'b110 && emdFlag && !stopReq) |=> (modemState == 3'b101 && !rxIrq && !idleIrq));

  p_rx_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (modemState == 3'b000 && idleIrq && $past(modemState) == 3'b110));

  p_frame_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    framingErr |-> (rxIrq && !$past(ignoreMissingEof)));

  p_idle_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    idleIrq |-> (modemState == 3'b000 && $past(modemState) != 3'b000));

  p_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && modemState != 3'b000) |=> (modemState == 3'b000 && idleIrq));

endmodule

bind xcvr_modem_seq xcvr_modem_seq_chk #(.WAIT_W(WAIT_W)) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .stopReq(stopReq), .rxWait(rxWait), .ignoreMissingEof(ignoreMissingEof),
  .emdFlag(emdFlag), .modemState(modemState), .txIrq(txIrq), .rxIrq(rxIrq),
  .idleIrq(idleIrq), .rxStart(rxStart), .framingErr(framingErr)
);

// File: tb/xcvr_modem_seq_tb_top.sv
module xcvr_modem_seq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdCode = 2'b00;
  logic       stopReq = 1'b0;
  logic [7:0] rxWait = 8'd0;
  logic       ignoreMissingEof = 1'b0;
  logic       txSofDone = 1'b0, txDataDone = 1'b0, txEofDone = 1'b0;
  logic       gridTick = 1'b0, cardSofDet = 1'b0, emdFlag = 1'b0;
  logic       rxEofOk = 1'b0, rxNoEof = 1'b0;
  logic [2:0] modemState;
  logic       txIrq, rxIrq, idleIrq, rxStart, framingErr;

  int checks = 0;
  int fails  = 0;
  int wdog   = 0;
  bit monOn  = 1'b0;
  bit done   = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk; // 200 MHz

  xcvr_modem_seq dut_i (.*);

  // event word: {txIrq, rxIrq, idleIrq, rxStart, framingErr, state}
  function automatic logic [7:0] ev(input logic t, input logic r, input logic i,
                                    input logic a, input logic f, input logic [2:0] s);
    return {t, r, i, a, f, s};
  endfunction

  task automatic expect_ev(input logic [7:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic check_state(input logic [2:0] exp, input string tag);
    checks++;
    if (modemState !== exp) begin
      fails++;
      $display("FAIL %s state actual=%b expected=%b", tag, modemState, exp);
    end
  endtask

  // monitor: every pulse cycle is compared with the oldest expected item
  always @(negedge clk) begin
    if (monOn && (txIrq | rxIrq | idleIrq | rxStart | framingErr)) begin
      logic [7:0] got;
      got = {txIrq, rxIrq, idleIrq, rxStart, framingErr, modemState};
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL unexpected-pulse actual=%b expected=none", got);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (got !== e) begin
          fails++;
          $display("FAIL %s event actual=%b expected=%b", t, got, e);
        end
      end
    end
  end

  // one-cycle pulse: 0 sofDone 1 dataDone 2 eofDone 3 tick 4 cardSof 5 emd 6 eofOk 7 noEof 8 stop
  task automatic hit(input int which);
    case (which)
      0: txSofDone = 1'b1;  1: txDataDone = 1'b1; 2: txEofDone = 1'b1;
      3: gridTick = 1'b1;   4: cardSofDet = 1'b1; 5: emdFlag = 1'b1;
      6: rxEofOk = 1'b1;    7: rxNoEof = 1'b1;    default: stopReq = 1'b1;
    endcase
    @(negedge clk);
    {txSofDone, txDataDone, txEofDone, gridTick, cardSofDet, emdFlag, rxEofOk, rxNoEof, stopReq} = '0;
  endtask

  task automatic command(input logic [1:0] c);
    cmdValid = 1'b1;
    cmdCode  = c;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdCode  = 2'b00;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wdog++;
    if (wdog > 20000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", wdog);
      summary();
    end
  end

  initial begin
    idle_cycles(3);
    rstN = 1'b1;
    idle_cycles(1);
    monOn = 1'b1;
    // R1 reset state
    check_state(3'b000, "R1");
    checks++;
    if ({txIrq, rxIrq, idleIrq, rxStart, framingErr} !== 5'b0) begin
      fails++;
      $display("FAIL R1 pulses actual=%b expected=00000", {txIrq, rxIrq, idleIrq, rxStart, framingErr});
    end
    command(2'b00);                   // R2 no-op code
    check_state(3'b000, "R2");

    // plain Send
    command(2'b01);
    check_state(3'b001, "R2");
    idle_cycles(2);
    check_state(3'b001, "R3");
    hit(0);
    check_state(3'b010, "R3");
    expect_ev(ev(1, 0, 0, 0, 0, 3'b011), "R3");
    hit(1);
    expect_ev(ev(0, 0, 1, 0, 0, 3'b000), "R4");
    hit(2);
    check_state(3'b000, "R4");

    // Exchange with wait 2 and gaps between ticks
    rxWait = 8'd2;
    command(2'b11);
    hit(0);
    expect_ev(ev(1, 0, 0, 0, 0, 3'b011), "R3");
    hit(1);
    hit(2);
    check_state(3'b100, "R4");
    rxWait = 8'd9;                    // R5 loaded value must be the one at entry
    hit(3); idle_cycles(3);
    hit(3); idle_cycles(2);
    check_state(3'b100, "R5");
    expect_ev(ev(0, 0, 0, 1, 0, 3'b101), "R5");
    hit(3);
    check_state(3'b101, "R5");
    command(2'b01);                   // R2 ignored while busy
    check_state(3'b101, "R2");
    hit(4);
    check_state(3'b110, "R6");
    hit(5);
    check_state(3'b101, "R7");
    hit(4);
    emdFlag = 1'b1;                   // R7 priority over eofOk
    rxEofOk = 1'b1;
    @(negedge clk);
    emdFlag = 1'b0;
    rxEofOk = 1'b0;
    check_state(3'b101, "R7");
    hit(4);
    expect_ev(ev(0, 1, 1, 0, 0, 3'b000), "R8");
    hit(6);
    check_state(3'b000, "R8");

    // Listen, zero wait, missing EOF reported
    rxWait = 8'd0;
    command(2'b10);
    check_state(3'b100, "R2");
    expect_ev(ev(0, 0, 0, 1, 0, 3'b101), "R5");
    hit(3);
    hit(4);
    expect_ev(ev(0, 1, 1, 0, 1, 3'b000), "R9");
    hit(7);
    check_state(3'b000, "R9");

    // Listen, missing EOF ignored
    ignoreMissingEof = 1'b1;
    command(2'b10);
    expect_ev(ev(0, 0, 0, 1, 0, 3'b101), "R5");
    hit(3);
    hit(4);
    expect_ev(ev(0, 1, 1, 0, 0, 3'b000), "R9");
    hit(7);
    check_state(3'b000, "R9");
    ignoreMissingEof = 1'b0;

    // stop mid-transmit, with a coder handshake in the same cycle
    command(2'b11);
    hit(0);
    expect_ev(ev(0, 0, 1, 0, 0, 3'b000), "R10");
    txDataDone = 1'b1;
    hit(8);
    check_state(3'b000, "R10");

    // stop during a long wait
    rxWait = 8'd255;
    command(2'b10);
    hit(3); hit(3);
    check_state(3'b100, "R5");
    expect_ev(ev(0, 0, 1, 0, 0, 3'b000), "R10");
    hit(8);
    check_state(3'b000, "R10");

    // stop while idle: no pulse, no change
    hit(8);
    check_state(3'b000, "R10");
    checks++;
    if (idleIrq !== 1'b0) begin
      fails++;
      $display("FAIL R10 idle-stop idleIrq actual=%b expected=0", idleIrq);
    end
    idle_cycles(3);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    summary();
  end

endmodule